// File: doc/BRIEF.md
# Register-Programmed Serial Port with Character FIFOs

This block is an asynchronous serial transceiver that software drives through five word registers on a simple single-cycle bus. A configuration register turns the port on, chooses parity (none, even or odd) over eight data bits, chooses one or two stop bits and can route the transmit line straight back into the receiver. A control/status register enables each direction, forces a break, picks the interrupt thresholds and reports queue, idle and error state. Characters written to the transmit port are queued in an eight-entry buffer and shifted out least significant bit first. Characters recovered by the receiver are queued in a second eight-entry buffer, each one carrying its own parity and framing error flags.

The bit clock comes from a divider register, so one bit lasts 16 × (divider + 1) system clocks. The receiver checks each start bit at its middle and samples every later bit at its middle. Three level interrupt outputs report receive data, transmit progress and faults (overrun or a bad character at the head of the receive queue).

Top module: `sio_port`

## Requirements
- R1: After reset the configuration register and divider read 0, the status register reads 0x0110 (bit 8 transmitter drained, bit 4 receiver idle), txd is high and all three interrupt outputs are low.
- R2: Each bit on txd lasts exactly 16 × (D + 1) clocks, where D is the value written at offset 0x40.
- R3: A frame is a low start bit, eight data bits LSB first, an optional parity bit and stop bits. Configuration bits [2:1] select the parity: 00 none, 01 even, 10 odd. Configuration bit 0 set gives two high stop bits, clear gives one.
- R4: The transmit queue holds 8 characters written at offset 0x20. Status bit 9 is set while it is full, and a write while full is dropped.
- R5: Status bit 8 is 1 only when the transmit queue is empty and the last stop bit has been sent.
- R6: A read at offset 0x30 returns the head received character in bits [7:0] and removes it. Status bit 0 is 1 while any character is queued. With status bit 12 (receiver enable) clear, nothing is received.
- R7: Configuration bit 6 feeds the transmitted stream into the receiver, and the rxd pin is ignored while it is set.
- R8: Status bits 3 and 2 give the parity error and the framing error of the character at the queue head, and they change as that character is removed.
- R9: A character arriving while the receive queue is full is dropped and sets status bit 1. The bit stays set until a status write with bit 1 = 0. That write clears it and empties the receive queue.
- R10: While status bit 11 is set and the port is on, txd is held low.
- R11: irq_rx follows status bits [7:6]: 00 at least one character queued, 01 at least half the queue, 10 or 11 a full queue.
- R12: irq_tx is low unless status bit 10 (transmit enable) is set. Status bits [15:14] then select the condition: 00 queue not full, 01 transmitter drained (bit 8), 10 or 11 queue empty.
- R13: irq_fault is high while the overrun flag is set, or while the head character has a parity or framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset: 0x00 config, 0x10 status, 0x20 transmit, 0x30 receive, 0x40 divider |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_fault | output | 1 | Overrun or bad head character |
| irq_rx | output | 1 | Receive threshold reached |
| irq_tx | output | 1 | Transmit condition met |

## Verification
The hardest state to reach is a receive queue with errors at its head. It needs frames with a wrong parity bit or a low stop bit, and a correct transmitter never sends those. The bench therefore drives such frames on rxd itself and uses loopback only for good traffic. The overrun case needs nine characters in a row with no reads. It is reached by looping nine characters back, then checking that the oldest one is still at the head, that a status write with bit 1 set leaves the flag alone, and that a write with bit 1 clear empties the queue.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
    // Register offsets (software decodes these)
    localparam logic [6:0] ADR_CFG  = 7'h00;
    localparam logic [6:0] ADR_STAT = 7'h10;
    localparam logic [6:0] ADR_TXD  = 7'h20;
    localparam logic [6:0] ADR_RXD  = 7'h30;
    localparam logic [6:0] ADR_DIV  = 7'h40;

    localparam int CHAR_W = 8;
    localparam int TICKS_PER_BIT = 16;

    // Shared frame phase encoding for both directions
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_e;
endpackage

// File: rtl/sio_fifo.sv
`timescale 1ns/1ps
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  do_push, do_pop;

    always_comb begin
        f_d     = f_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            f_d.mem[f_q.wp] = din;
            f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) begin
            f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign dout  = f_q.mem[f_q.rp];
    assign count = f_q.cnt;
    assign full  = (f_q.cnt == CW'(DEPTH));
    assign empty = (f_q.cnt == '0);
endmodule

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              two_stop,
    input  logic [1:0]        par_mode,
    input  logic              has_data,
    input  logic [CHAR_W-1:0] data,
    input  logic              brk,
    output logic              pop,
    output logic              line,
    output logic              busy
);
    localparam logic [3:0] LAST_TICK = 4'(TICKS_PER_BIT - 1);

    typedef struct packed {
        phase_e            ph;
        logic [3:0]        sub;
        logic [2:0]        bitn;
        logic [CHAR_W-1:0] sh;
        logic              pbit;
    } tx_t;

    tx_t t_d, t_q;
    logic raw;

    always_comb begin
        t_d = t_q;
        pop = 1'b0;
        if (!run) begin
            t_d = '0;
        end else if (tick) begin
            if (t_q.ph == PH_IDLE) begin
                if (has_data) begin
                    pop      = 1'b1;
                    t_d.sh   = data;
                    t_d.pbit = (^data) ^ par_mode[1];
                    t_d.ph   = PH_START;
                    t_d.sub  = '0;
                    t_d.bitn = '0;
                end
            end else begin
                t_d.sub = t_q.sub + 4'd1;
                if (t_q.sub == LAST_TICK) begin
                    case (t_q.ph)
                        PH_START: t_d.ph = PH_DATA;
                        PH_DATA: begin
                            t_d.sh   = t_q.sh >> 1;
                            t_d.bitn = t_q.bitn + 3'd1;
                            if (t_q.bitn == 3'd7)
                                t_d.ph = (par_mode != 2'b00) ? PH_PAR : PH_STOP;
                        end
                        PH_PAR: t_d.ph = PH_STOP;
                        default: begin
                            if (two_stop && t_q.bitn == 3'd0) t_d.bitn = 3'd1;
                            else                             t_d.ph   = PH_IDLE;
                        end
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (t_q.ph)
            PH_START: raw = 1'b0;
            PH_DATA:  raw = t_q.sh[0];
            PH_PAR:   raw = t_q.pbit;
            default:  raw = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign line = brk ? 1'b0 : raw;
    assign busy = (t_q.ph != PH_IDLE);
endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              line,
    input  logic [1:0]        par_mode,
    output logic              push,
    output logic [CHAR_W-1:0] data,
    output logic              perr,
    output logic              ferr,
    output logic              idle
);
    localparam logic [3:0] LAST_TICK = 4'(TICKS_PER_BIT - 1);
    localparam logic [3:0] MID_TICK  = 4'(TICKS_PER_BIT / 2 - 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              armed;
        phase_e            ph;
        logic [3:0]        sub;
        logic [2:0]        bitn;
        logic [CHAR_W-1:0] sh;
        logic              perr;
    } rx_t;

    rx_t r_d, r_q;
    logic ln;

    assign ln = r_q.s2;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = line;
        r_d.s2 = r_q.s1;
        push   = 1'b0;
        if (!run) begin
            r_d.ph    = PH_IDLE;
            r_d.sub   = '0;
            r_d.bitn  = '0;
            r_d.armed = 1'b0;
        end else if (tick) begin
            case (r_q.ph)
                PH_IDLE: begin
                    if (ln) r_d.armed = 1'b1;
                    else if (r_q.armed) begin
                        r_d.ph  = PH_START;
                        r_d.sub = '0;
                    end
                end
                PH_START: begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == MID_TICK) begin
                        if (!ln) begin
                            r_d.ph   = PH_DATA;
                            r_d.sub  = '0;
                            r_d.bitn = '0;
                            r_d.perr = 1'b0;
                        end else begin
                            r_d.ph = PH_IDLE;
                        end
                    end
                end
                default: begin
                    r_d.sub = r_q.sub + 4'd1;
                    if (r_q.sub == LAST_TICK) begin
                        case (r_q.ph)
                            PH_DATA: begin
                                r_d.sh   = {ln, r_q.sh[CHAR_W-1:1]};
                                r_d.bitn = r_q.bitn + 3'd1;
                                if (r_q.bitn == 3'd7)
                                    r_d.ph = (par_mode != 2'b00) ? PH_PAR : PH_STOP;
                            end
                            PH_PAR: begin
                                r_d.perr = ln ^ (^r_q.sh) ^ par_mode[1];
                                r_d.ph   = PH_STOP;
                            end
                            default: begin
                                push      = 1'b1;
                                r_d.ph    = PH_IDLE;
                                r_d.armed = 1'b0;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1, ph: PH_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign data = r_q.sh;
    assign perr = r_q.perr;
    assign ferr = !ln;
    assign idle = (r_q.ph == PH_IDLE);
endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
    import sio_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [6:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq_fault,
    output logic        irq_rx,
    output logic        irq_tx
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int RX_W = CHAR_W + 2;
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic             on;
        logic             lpbk;
        logic [1:0]       par;
        logic             two_stop;
        logic [1:0]       txsel;
        logic             rxen;
        logic             brk;
        logic             txen;
        logic [1:0]       rxsel;
        logic             oerr;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic            tick, wr, rd, stat_wr, flush;
    logic            tx_pop, tx_full, tx_empty, tx_busy, tx_line, trmt;
    logic [CHAR_W-1:0] tx_head;
    logic [CW-1:0]   tx_cnt, rx_cnt;
    logic            rx_push, rx_perr, rx_ferr, rx_idle, rx_full, rx_empty, rx_pop;
    logic [CHAR_W-1:0] rx_char;
    logic [RX_W-1:0] rx_head;
    logic            head_perr, head_ferr, rx_line;
    logic [15:0]     stat_v;
    logic            unused_bits;

    assign wr      = bus_en && bus_we;
    assign rd      = bus_en && !bus_we;
    assign stat_wr = wr && (bus_addr == ADR_STAT);
    assign tick    = r_q.on && (r_q.cnt == r_q.div);
    assign rx_pop  = rd && (bus_addr == ADR_RXD);

    always_comb begin
        r_d   = r_q;
        flush = 1'b0;
        r_d.cnt = (!r_q.on || tick) ? '0 : r_q.cnt + 1'b1;
        if (wr) begin
            case (bus_addr)
                ADR_CFG: begin
                    r_d.on       = bus_wdata[15];
                    r_d.lpbk     = bus_wdata[6];
                    r_d.par      = bus_wdata[2:1];
                    r_d.two_stop = bus_wdata[0];
                end
                ADR_STAT: begin
                    r_d.txsel = bus_wdata[15:14];
                    r_d.rxen  = bus_wdata[12];
                    r_d.brk   = bus_wdata[11];
                    r_d.txen  = bus_wdata[10];
                    r_d.rxsel = bus_wdata[7:6];
                    if (!bus_wdata[1]) begin
                        flush    = r_q.oerr;
                        r_d.oerr = 1'b0;
                    end
                end
                ADR_DIV: begin
                    r_d.div = DIV_W'(bus_wdata);
                    r_d.cnt = '0;
                end
                default: ;
            endcase
        end
        if (rx_push && rx_full) r_d.oerr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    sio_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(wr && (bus_addr == ADR_TXD)), .din(bus_wdata[CHAR_W-1:0]),
        .pop(tx_pop), .dout(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .run(r_q.on && r_q.txen), .tick(tick),
        .two_stop(r_q.two_stop), .par_mode(r_q.par),
        .has_data(!tx_empty), .data(tx_head), .brk(r_q.brk),
        .pop(tx_pop), .line(tx_line), .busy(tx_busy)
    );

    assign rx_line = r_q.lpbk ? tx_line : rxd;

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .run(r_q.on && r_q.rxen), .tick(tick),
        .line(rx_line), .par_mode(r_q.par),
        .push(rx_push), .data(rx_char), .perr(rx_perr), .ferr(rx_ferr),
        .idle(rx_idle)
    );

    sio_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_push), .din({rx_perr, rx_ferr, rx_char}),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    assign trmt      = tx_empty && !tx_busy;
    assign head_perr = !rx_empty && rx_head[RX_W-1];
    assign head_ferr = !rx_empty && rx_head[RX_W-2];

    assign stat_v = {r_q.txsel, 1'b0, r_q.rxen, r_q.brk, r_q.txen,
                     tx_full, trmt, r_q.rxsel, 1'b0, rx_idle,
                     head_perr, head_ferr, r_q.oerr, !rx_empty};

    always_comb begin
        case (bus_addr)
            ADR_CFG:  bus_rdata = {r_q.on, 8'h00, r_q.lpbk, 3'b000, r_q.par, r_q.two_stop};
            ADR_STAT: bus_rdata = stat_v;
            ADR_RXD:  bus_rdata = {8'h00, rx_head[CHAR_W-1:0]};
            ADR_DIV:  bus_rdata = 16'(r_q.div);
            default:  bus_rdata = 16'h0000;
        endcase
    end

    assign txd = r_q.on ? tx_line : 1'b1;

    always_comb begin
        case (r_q.rxsel)
            2'b00:   irq_rx = r_q.on && !rx_empty;
            2'b01:   irq_rx = r_q.on && (rx_cnt >= HALF);
            default: irq_rx = r_q.on && (rx_cnt == FULL);
        endcase
        case (r_q.txsel)
            2'b00:   irq_tx = r_q.on && r_q.txen && !tx_full;
            2'b01:   irq_tx = r_q.on && r_q.txen && trmt;
            default: irq_tx = r_q.on && r_q.txen && tx_empty;
        endcase
    end

    assign irq_fault = r_q.on && (r_q.oerr || head_perr || head_ferr);

    assign unused_bits = ^{bus_wdata[13], bus_wdata[9:2], bus_wdata[15:8]};
endmodule

// File: rtl/sio_port_chk.sv
`timescale 1ns/1ps
module sio_port_chk #(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    txd,
    input logic                    on,
    input logic                    brk,
    input logic                    trmt,
    input logic                    oerr,
    input logic                    stat_wr,
    input logic                    wd1,
    input logic                    irq_rx,
    input logic                    irq_fault,
    input logic [$clog2(DEPTH):0]  tx_cnt,
    input logic [$clog2(DEPTH):0]  rx_cnt,
    input logic [DIV_W-1:0]        cnt,
    input logic [DIV_W-1:0]        div
);
    // R10: break holds the line low
    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (on && brk) |-> !txd);

    // R5: drained transmitter leaves the line at the stop level
    a_r5_drained_high: assert property (@(posedge clk) disable iff (!rst_n)
        (trmt && !brk) |-> txd);

    // R4: transmit queue never exceeds its depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

    // R9: overrun flag is sticky until a clearing write
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr && !(stat_wr && !wd1)) |=> oerr);

    // R9: clearing write empties the receive queue
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr && stat_wr && !wd1) |=> (rx_cnt == '0));

    // R11: receive interrupt never fires on an empty queue
    a_r11_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (rx_cnt != '0));

    // R13: overrun always raises the fault line
    a_r13_fault_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (oerr && on) |-> irq_fault);

    // R2: divider counter stays within the programmed limit
    a_r2_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div);
endmodule

bind sio_port sio_port_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .on(r_q.on), .brk(r_q.brk),
    .trmt(trmt), .oerr(r_q.oerr), .stat_wr(stat_wr), .wd1(bus_wdata[1]),
    .irq_rx(irq_rx), .irq_fault(irq_fault), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .cnt(r_q.cnt), .div(r_q.div)
);

// File: tb/sio_port_tb.sv
`timescale 1ns/1ps
module sio_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq_fault, irq_rx, irq_tx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_fault(irq_fault), .irq_rx(irq_rx),
        .irq_tx(irq_tx)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    // ---------------- reference model of the line ----------------
    // exp_line: 0 = no expectation, 1 = must be high, 2 = must be low
    int exp_line = 0;
    always @(negedge clk) begin
        if (rst_n && exp_line != 0 && !done) begin
            checks++;
            if (txd !== (exp_line == 1)) begin
                fails++;
                $display("FAIL R10/R1 line model: actual %0b expected %0b", txd, exp_line == 1);
            end
        end
    end

    // Behavioural frame monitor: decodes txd into a queue of characters
    int  bitclk   = 32;
    int  mon_par  = 0;   // 0 none, 1 even, 2 odd
    bit  mon_two  = 0;
    bit  mon_en   = 1;
    int  mon_bad  = 0;
    byte mq[$];

    always begin
        @(negedge clk);
        if (rst_n && mon_en && txd === 1'b0) begin
            logic [7:0] c;
            logic pb;
            repeat (bitclk / 2 - 1) @(negedge clk);
            if (txd !== 1'b0) mon_bad++;
            for (int i = 0; i < 8; i++) begin
                repeat (bitclk) @(negedge clk);
                c[i] = txd;
            end
            if (mon_par != 0) begin
                repeat (bitclk) @(negedge clk);
                pb = txd;
                if (pb !== ((^c) ^ (mon_par == 2))) mon_bad++;
            end
            repeat (bitclk) @(negedge clk);
            if (txd !== 1'b1) mon_bad++;
            if (mon_two) begin
                repeat (bitclk) @(negedge clk);
                if (txd !== 1'b1) mon_bad++;
            end
            mq.push_back(c);
        end
    end

    task automatic wait_drained();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(7'h10, s);
            if (s[8]) break;
        end
        repeat (bitclk) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] c, input bit with_par, input bit par_v, input bit stop_v);
        @(negedge clk);
        rxd = 1'b0; repeat (32) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = c[i]; repeat (32) @(negedge clk);
        end
        if (with_par) begin rxd = par_v; repeat (32) @(negedge clk); end
        rxd = stop_v; repeat (32) @(negedge clk);
        rxd = 1'b1; repeat (64) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] s;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(7'h10, s); chk(s == 16'h0110, "R1 status", s, 16'h0110);
        rd(7'h00, s); chk(s == 16'h0000, "R1 config", s, 0);
        rd(7'h40, s); chk(s == 16'h0000, "R1 divider", s, 0);
        chk({irq_fault, irq_rx, irq_tx} == 3'b000, "R1 irqs", {irq_fault, irq_rx, irq_tx}, 0);
        chk(txd == 1'b1, "R1 txd", txd, 1);

        // R2: bit time with divider 1
        wr(7'h40, 16'd1);
        wr(7'h00, 16'h8000);
        wr(7'h10, 16'h1400);
        mq.delete();
        wr(7'h20, 16'h0001);
        // R5: not drained right after a write
        rd(7'h10, s); chk(s[8] == 1'b0, "R5 busy after write", s[8], 0);
        n = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin n++; @(negedge clk); end
        chk(n == 32, "R2 bit time div=1", n, 32);
        wait_drained();
        rd(7'h10, s); chk(s[8] == 1'b1, "R5 drained", s[8], 1);
        chk(mq.size() == 1 && mq[0] == 8'h01, "R3 8N1 char", mq.size() ? mq[0] : -1, 1);

        // R3: even, odd parity and two stop bits
        mq.delete(); mon_par = 1;
        wr(7'h00, 16'h8002); wr(7'h20, 16'h00A5); wr(7'h20, 16'h0037);
        wait_drained();
        mon_par = 2;
        wr(7'h00, 16'h8004); wr(7'h20, 16'h00A5); wr(7'h20, 16'h0037);
        wait_drained();
        mon_par = 0; mon_two = 1;
        wr(7'h00, 16'h8001); wr(7'h20, 16'h005A); wr(7'h20, 16'h00C3);
        wait_drained();
        mon_two = 0;
        chk(mq.size() == 6, "R3 frame count", mq.size(), 6);
        chk(mq.size() == 6 && mq[0] == 8'hA5 && mq[3] == 8'h37 && mq[5] == 8'hC3,
            "R3 frame data", mq.size() ? mq[5] : -1, 8'hC3);
        chk(mon_bad == 0, "R3 parity/stop bits", mon_bad, 0);

        // R4 / R12: fill the transmit queue with the transmitter off
        wr(7'h00, 16'h8000);
        wr(7'h10, 16'h1000);
        mq.delete();
        for (int i = 0; i < 9; i++) wr(7'h20, 16'h0010 + 16'(i));
        rd(7'h10, s); chk(s[9] == 1'b1, "R4 full flag", s[9], 1);
        chk(irq_tx == 1'b0, "R12 gated by enable", irq_tx, 0);
        wr(7'h10, 16'h9400);
        @(negedge clk);
        chk(irq_tx == 1'b0, "R12 empty-select while queued", irq_tx, 0);
        wait_drained();
        chk(irq_tx == 1'b1, "R12 empty-select after drain", irq_tx, 1);
        chk(mq.size() == 8, "R4 ninth write dropped", mq.size(), 8);
        chk(mq.size() == 8 && mq[7] == 8'h17, "R4 last char", mq.size() ? mq[mq.size()-1] : -1, 8'h17);
        wr(7'h10, 16'h5400);
        @(negedge clk);
        chk(irq_tx == 1'b1, "R12 drained-select", irq_tx, 1);

        // R7: loopback, external rxd ignored
        wr(7'h10, 16'h1400);
        wr(7'h00, 16'h8040);
        rxd = 1'b0;
        wr(7'h20, 16'h003C);
        wait_drained();
        rd(7'h10, s); chk(s[0] == 1'b1, "R6 data available", s[0], 1);
        chk(irq_rx == 1'b1, "R11 one char select 00", irq_rx, 1);
        rd(7'h30, s); chk(s[7:0] == 8'h3C, "R7 loopback data", s[7:0], 8'h3C);
        rd(7'h10, s); chk(s[0] == 1'b0, "R6 popped", s[0], 0);
        chk(irq_rx == 1'b0, "R11 empty", irq_rx, 0);

        // R11: half threshold
        wr(7'h10, 16'h1440);
        for (int i = 0; i < 3; i++) wr(7'h20, 16'h0061 + 16'(i));
        wait_drained();
        chk(irq_rx == 1'b0, "R11 three below half", irq_rx, 0);
        wr(7'h20, 16'h0064);
        wait_drained();
        chk(irq_rx == 1'b1, "R11 half reached", irq_rx, 1);
        wr(7'h10, 16'h1480);
        @(negedge clk);
        chk(irq_rx == 1'b0, "R11 full select", irq_rx, 0);
        wr(7'h10, 16'h1400);
        for (int i = 0; i < 4; i++) begin
            rd(7'h30, s);
            chk(s[7:0] == 8'(8'h61 + i), "R6 fifo order", s[7:0], 8'h61 + i);
        end

        // R6: receiver disabled
        wr(7'h10, 16'h0400);
        wr(7'h20, 16'h0077);
        wait_drained();
        rd(7'h10, s); chk(s[0] == 1'b0, "R6 rx disabled", s[0], 0);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        wr(7'h10, 16'h1400);
        wr(7'h00, 16'h8002);

        // R8 / R13: error frames on rxd, even parity
        send_frame(8'h55, 1'b1, ~(^8'h55), 1'b1);
        send_frame(8'h66, 1'b1, ^8'h66, 1'b0);
        rd(7'h10, s); chk(s[3:2] == 2'b10, "R8 parity error at head", s[3:2], 2'b10);
        chk(irq_fault == 1'b1, "R13 fault on parity error", irq_fault, 1);
        rd(7'h30, s); chk(s[7:0] == 8'h55, "R8 first data", s[7:0], 8'h55);
        rd(7'h10, s); chk(s[3:2] == 2'b01, "R8 framing error at head", s[3:2], 2'b01);
        chk(irq_fault == 1'b1, "R13 fault on framing error", irq_fault, 1);
        rd(7'h30, s); chk(s[7:0] == 8'h66, "R8 second data", s[7:0], 8'h66);
        rd(7'h10, s); chk(s[3:0] == 4'b0000, "R8 clean when empty", s[3:0], 0);
        chk(irq_fault == 1'b0, "R13 fault clear", irq_fault, 0);

        // R9: overrun
        wr(7'h00, 16'h8040);
        for (int i = 0; i < 9; i++) wr(7'h20, 16'h0040 + 16'(i));
        wait_drained();
        rd(7'h10, s); chk(s[1] == 1'b1, "R9 overrun set", s[1], 1);
        chk(irq_fault == 1'b1, "R13 fault on overrun", irq_fault, 1);
        rd(7'h30, s); chk(s[7:0] == 8'h40, "R9 oldest kept", s[7:0], 8'h40);
        wr(7'h10, 16'h1402);
        rd(7'h10, s); chk(s[1:0] == 2'b11, "R9 sticky on write of 1", s[1:0], 2'b11);
        wr(7'h10, 16'h1400);
        rd(7'h10, s); chk(s[1:0] == 2'b00, "R9 cleared and flushed", s[1:0], 0);
        chk(irq_fault == 1'b0, "R13 fault released", irq_fault, 0);

        // R10: break
        wr(7'h00, 16'h8000);
        mon_en = 0;
        wr(7'h10, 16'h1C00);
        @(negedge clk);
        exp_line = 2;
        repeat (100) @(negedge clk);
        chk(txd == 1'b0, "R10 break low", txd, 0);
        exp_line = 0;
        wr(7'h10, 16'h1400);
        @(negedge clk);
        exp_line = 1;
        repeat (50) @(negedge clk);
        chk(txd == 1'b1, "R10 break released", txd, 1);
        exp_line = 0;
        mon_en = 1;

        // R2: bit time with divider 3
        wr(7'h40, 16'd3);
        bitclk = 64;
        mq.delete();
        wr(7'h20, 16'h0001);
        n = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin n++; @(negedge clk); end
        chk(n == 64, "R2 bit time div=3", n, 64);
        wait_drained();
        chk(mq.size() == 1 && mq[0] == 8'h01, "R3 char at div=3", mq.size() ? mq[0] : -1, 1);

        // R1/R10: port off keeps the line idle
        wr(7'h00, 16'h0000);
        wr(7'h10, 16'h1C00);
        @(negedge clk);
        exp_line = 1;
        wr(7'h20, 16'h00AA);
        repeat (300) @(negedge clk);
        exp_line = 0;
        chk(irq_tx == 1'b0 && irq_rx == 1'b0, "R1 port off irqs", {irq_rx, irq_tx}, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule